// File: doc/BRIEF.md
# Programmable-Flag Offset Register Port

This block keeps the two threshold values that a dual-clock FIFO's programmable flags compare against: the almost-empty offset and the almost-full offset. Software or a host loads and reads them without an address bus. It pulls an active-low load-select input low, and the FIFO's ordinary write and read strobes are then steered to this register pair instead of the data memory.

Writes are taken on the write clock and reads on the read clock. Each side walks the pair with its own one-bit pointer. The pointer selects the almost-empty offset first, then the almost-full offset, and then wraps back. The write and read pointers never influence each other.

Both offsets are driven continuously to the flag logic. At reset they take a default that depends on the FIFO depth.

Top module: `ofs_port`

## Requirements
- R1: While reset is asserted, both offsets equal the depth default (31 for a depth up to 256, 63 for 512, 127 for 1024 and deeper), both pointers select the almost-empty offset, and `rd_data` is zero.
- R2: With `load_n` low and `wr_en_n` low, a rising `wclk` edge stores bits [OFS_W-1:0] of `wr_data` into the register the write pointer selects, where OFS_W = log2(DEPTH). The stored value appears on `empty_ofs` or `full_ofs` after that edge.
- R3: Each accepted write moves the write pointer from almost-empty to almost-full, or from almost-full back to almost-empty.
- R4: With `load_n` low and `wr_en_n` high, a `wclk` edge writes nothing and leaves the write pointer where it is.
- R5: With `load_n` low and `rd_en_n` low, a rising `rclk` edge loads the register the read pointer selects onto `rd_data` and moves the read pointer in the same almost-empty, almost-full, wrap order.
- R6: Bits [17:OFS_W] of `rd_data` are always zero.
- R7: Reads never move the write pointer, and writes never move the read pointer.
- R8: With `load_n` high, both strobes are ignored: no register changes, neither pointer moves, and `rd_data` holds.
- R9: `rd_data` holds its value on every `rclk` edge without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Steers strobes to the offset registers when low |
| wr_en_n | input | 1 | Write strobe, active low |
| rd_en_n | input | 1 | Read strobe, active low |
| wr_data | input | 18 | Write data bus |
| rd_data | output | 18 | Read-back data, zero-extended |
| empty_ofs | output | OFS_W | Almost-empty offset to the flag logic |
| full_ofs | output | OFS_W | Almost-full offset to the flag logic |

## Verification
The bench builds two copies side by side from the same stimulus. One uses DEPTH 256, which gives 8-bit offsets and a default of 31. The other uses DEPTH 1024, which gives 10-bit offsets and a default of 127. Together they cover two branches of the default selection. They also show that the same 18-bit write lands truncated to different widths, and that different upper bits read back as zero. A shared scoreboard compares both read-back paths, including reads across pointer wrap and after a mid-run reset.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;

  // Offset loaded at reset for a given FIFO depth
  function automatic int unsigned dflt_offset(int unsigned depth);
    if (depth <= 256) return 31;
    else if (depth <= 512) return 63;
    else return 127;
  endfunction

  // Pointer step: almost-empty -> almost-full -> wrap
  function automatic ofs_sel_e next_sel(ofs_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/ofs_ptr.sv
module ofs_ptr
  import ofs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  output ofs_sel_e sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= SEL_EMPTY;
    else if (adv) sel <= next_sel(sel);
  end
endmodule

// File: rtl/ofs_store.sv
module ofs_store
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned DATA_W = 18,
  parameter logic [OFS_W-1:0] DFLT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  ofs_sel_e          sel,
  input  logic [DATA_W-1:0] din,
  output logic [OFS_W-1:0]  empty_q,
  output logic [OFS_W-1:0]  full_q
);
  logic [1:0][OFS_W-1:0] regs;

  for (genvar i = 0; i < 2; i++) begin : g_reg
    logic [OFS_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= DFLT;
      else if (we && sel == ofs_sel_e'(i)) q <= din[OFS_W-1:0];
    end
    assign regs[i] = q;
  end

  assign empty_q = regs[SEL_EMPTY];
  assign full_q  = regs[SEL_FULL];
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  ofs_sel_e          sel,
  input  logic [OFS_W-1:0]  empty_q,
  input  logic [OFS_W-1:0]  full_q,
  output logic [DATA_W-1:0] dout
);
  logic [OFS_W-1:0] picked;
  assign picked = (sel == SEL_EMPTY) ? empty_q : full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else if (re) dout <= DATA_W'(picked);
  end
endmodule

// File: rtl/ofs_port.sv
module ofs_port
  import ofs_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 18,
  localparam int unsigned OFS_W = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              wr_en_n,
  input  logic              rd_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs
);
  localparam logic [OFS_W-1:0] DFLT = OFS_W'(dflt_offset(DEPTH));

  // Named events for the checker
  logic     wr_fire, rd_fire;
  ofs_sel_e wr_ptr, rd_ptr;

  assign wr_fire = !load_n && !wr_en_n;
  assign rd_fire = !load_n && !rd_en_n;

  ofs_ptr u_wptr (.clk(wclk), .rst_n(rst_n), .adv(wr_fire), .sel(wr_ptr));
  ofs_ptr u_rptr (.clk(rclk), .rst_n(rst_n), .adv(rd_fire), .sel(rd_ptr));

  ofs_store #(.OFS_W(OFS_W), .DATA_W(DATA_W), .DFLT(DFLT)) u_store (
    .clk(wclk), .rst_n(rst_n), .we(wr_fire), .sel(wr_ptr), .din(wr_data),
    .empty_q(empty_ofs), .full_q(full_ofs)
  );

  ofs_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rb (
    .clk(rclk), .rst_n(rst_n), .re(rd_fire), .sel(rd_ptr),
    .empty_q(empty_ofs), .full_q(full_ofs), .dout(rd_data)
  );
endmodule

// File: rtl/ofs_port_chk.sv
module ofs_port_chk
  import ofs_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 18,
  localparam int unsigned OFS_W = $clog2(DEPTH)
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              wr_fire,
  input logic              rd_fire,
  input ofs_sel_e          wr_ptr,
  input ofs_sel_e          rd_ptr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs
);
  // R2
  wr_empty_store_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_fire && wr_ptr == SEL_EMPTY) |=> (empty_ofs == $past(wr_data[OFS_W-1:0]) && $stable(full_ofs)));
  // R2
  wr_full_store_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_fire && wr_ptr == SEL_FULL) |=> (full_ofs == $past(wr_data[OFS_W-1:0]) && $stable(empty_ofs)));
  // R3
  wr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_fire |=> wr_ptr != $past(wr_ptr));
  // R4
  wr_idle_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !wr_fire |=> ($stable(wr_ptr) && $stable(empty_ofs) && $stable(full_ofs)));
  // R5
  rd_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_fire |=> rd_ptr != $past(rd_ptr));
  // R6
  rd_upper_zero_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_data[DATA_W-1:OFS_W] == '0);
  // R9
  rd_idle_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_fire |=> ($stable(rd_data) && $stable(rd_ptr)));
endmodule

bind ofs_port ofs_port_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_data(wr_data), .rd_data(rd_data),
  .empty_ofs(empty_ofs), .full_ofs(full_ofs)
);

// File: tb/ofs_port_tb.sv
module ofs_port_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, load_n, wr_en_n, rd_en_n;
  logic [17:0] wr_data;
  logic [17:0] dout_a, dout_b;
  logic [7:0]  eo_a, fo_a;
  logic [9:0]  eo_b, fo_b;

  ofs_port #(.DEPTH(256)) u_dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .wr_data(wr_data), .rd_data(dout_a),
    .empty_ofs(eo_a), .full_ofs(fo_a));
  ofs_port #(.DEPTH(1024)) u_dut_wide (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .wr_data(wr_data), .rd_data(dout_b),
    .empty_ofs(eo_b), .full_ofs(fo_b));

  int compared = 0, mismatched = 0;
  logic [7:0] ma [2];
  logic [9:0] mb [2];
  int wp, rp;
  logic [35:0] sb_q[$];
  logic [17:0] last_a, last_b;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    ma[0] = 8'd31; ma[1] = 8'd31; mb[0] = 10'd127; mb[1] = 10'd127;
    wp = 0; rp = 0; last_a = '0; last_b = '0;
  endtask

  task automatic check_ofs(string tag);
    chk({tag, " empty256"}, 32'(eo_a), 32'(ma[0]));
    chk({tag, " full256"},  32'(fo_a), 32'(ma[1]));
    chk({tag, " empty1024"}, 32'(eo_b), 32'(mb[0]));
    chk({tag, " full1024"},  32'(fo_b), 32'(mb[1]));
  endtask

  // driver: accepted write
  task automatic wr(logic [17:0] v);
    @(negedge clk); load_n = 0; wr_en_n = 0; wr_data = v;
    @(negedge clk); load_n = 1; wr_en_n = 1;
    ma[wp] = v[7:0]; mb[wp] = v[9:0]; wp ^= 1;
    check_ofs("R2/R3 write");
  endtask

  // driver: accepted read, expected item pushed to scoreboard
  task automatic rd();
    @(negedge clk); load_n = 0; rd_en_n = 0;
    sb_q.push_back({18'(ma[rp]), 18'(mb[rp])});
    last_a = 18'(ma[rp]); last_b = 18'(mb[rp]); rp ^= 1;
    @(negedge clk); load_n = 1; rd_en_n = 1;
  endtask

  // monitor: pops expected items on accepted reads
  always @(posedge clk) begin
    automatic logic fire = rst_n && !load_n && !rd_en_n;
    #1;
    if (fire) begin
      if (sb_q.size() == 0) chk("R5 scoreboard empty", 1, 0);
      else begin
        automatic logic [35:0] it = sb_q.pop_front();
        chk("R5/R6 read 256", 32'(dout_a), 32'(it[35:18]));
        chk("R5/R6 read 1024", 32'(dout_b), 32'(it[17:0]));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 0; load_n = 1; wr_en_n = 1; rd_en_n = 1; wr_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 defaults during reset
    check_ofs("R1 reset");
    chk("R1 rd_data 256", 32'(dout_a), 0);
    chk("R1 rd_data 1024", 32'(dout_b), 0);
    rst_n = 1;
    @(negedge clk);

    // R5 read defaults, then wrap back to empty
    rd(); rd(); rd();
    // R2/R3 writes: empty, full, wrap to empty
    wr(18'h3FF05);
    wr(18'h2A5C3);
    wr(18'h00011);
    // R7: reads did not move write ptr; writes did not move read ptr (rp at full)
    rd(); rd(); rd();
    // write ptr at full: all-ones data, R6 upper bits zero on read-back
    wr(18'h3FFFF);
    rd(); rd();

    // R4: load low, write strobe high -> nothing written
    @(negedge clk); load_n = 0; wr_en_n = 1; wr_data = 18'h15A5A;
    @(negedge clk); load_n = 1;
    check_ofs("R4 inhibited write");
    wr(18'h00042);  // goes to empty: proves write pointer did not move (R4)

    // R8: load high, both strobes active (each alone)
    @(negedge clk); load_n = 1; wr_en_n = 0; wr_data = 18'h0BEEF;
    @(negedge clk); wr_en_n = 1; rd_en_n = 0;
    @(negedge clk); rd_en_n = 1;
    check_ofs("R8 load high");
    chk("R8 rd_data hold 256", 32'(dout_a), 32'(last_a));
    chk("R8 rd_data hold 1024", 32'(dout_b), 32'(last_b));
    rd();  // pointer position confirms R8
    wr(18'h00077);  // write pointer confirms R8 (full slot)

    // R9: idle cycles hold rd_data
    repeat (3) @(negedge clk);
    chk("R9 hold 256", 32'(dout_a), 32'(last_a));
    chk("R9 hold 1024", 32'(dout_b), 32'(last_b));

    // R1 mid-run reset
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk);
    check_ofs("R1 mid reset");
    chk("R1 mid rd_data", 32'(dout_a), 0);
    rst_n = 1;
    wr(18'h00003);  // pointer back at empty (R1)
    rd(); rd();

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule